// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator with Output Routing

This block turns a pair of held sample values, one for the left source and one for the right, into two one-bit pulse-width outputs. One period counter is shared by both outputs. It counts up once per clock and wraps at a programmed period length. Each output stays high while the counter is below the sample routed to it. Before the compare, a sample is limited to the period length. As a result, a sample equal to or larger than the period gives an output that is high for the whole period.

A 4-bit routing code chooses which source drives which output. The choices are straight through, crossed over, a single source to a single side, or muted.

A FIFO controller upstream presents samples with a one-cycle strobe, and each strobe fills a staging register. The period length, the routing code and the staged samples reach the active copies only when the counter wraps. A pulse that is already running is therefore never cut short or stretched. A period length of zero stops the counter and holds both outputs low.

Top module: `pwm_route_mod`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, both outputs are low.
- R2: With routing code 4'h5, the left output carries the left sample and the right output carries the right sample.
- R3: With routing code 4'hA, the left output carries the right sample and the right output carries the left sample.
- R4: Routing codes 4'h0, 4'h6, 4'h9 and 4'hF mute both outputs.
- R5: Any other code drives exactly one output from one source. The source is the right sample when code bit 1 or bit 2 is set, and the left sample otherwise. The destination is the right output when code bit 2 or bit 3 is set, and the left output otherwise. The other output stays low.
- R6: A sample larger than the active period length is limited to that length, so the output it drives is high for every cycle of the period.
- R7: While the active period length is zero, the counter is held at zero and both outputs are low.
- R8: Within a period of length P, an output driven by a limited sample value S is high for the first S cycles and low for the remaining P-S cycles.
- R9: A new period length, routing code or staged sample takes effect only at a counter wrap. A strobe or code change in the middle of a period leaves that period unchanged. If the strobe falls on the wrap cycle itself, the sample given with that strobe is loaded.
- R10: With a non-zero active period length P, the counter stays below P and repeats the cycle 0 through P-1. The first period starts on the clock after a load made from the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| periodIn | input | 12 | Requested period length in clocks; 0 stops modulation |
| modeIn | input | 4 | Requested routing code |
| sampleLeft | input | 12 | Left source sample |
| sampleRight | input | 12 | Right source sample |
| sampleStrobe | input | 1 | Captures both samples into staging |
| pwmLeft | output | 1 | Left pulse-width output |
| pwmRight | output | 1 | Right pulse-width output |

## Verification
The bench builds the block with its default 12-bit sample and period width. It programs periods of 0 and of 6 to 12 clocks. Periods this short let every cycle of a pulse be compared one by one, and they bring the limiting case, where a sample of 4095 meets a period of 6, within a few clocks. Each scenario returns the block to the stopped state first, so the next load lands on a known clock. The bench can then place a mid-period strobe and code change at an exact counter position and confirm that the change shows up only in the following period.

// File: rtl/pwm_route_pkg.sv
package pwm_route_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadActive;  // copy requested settings into the active registers
    logic running;     // active period is non-zero
  } pwmStrobes_t;

  // Decoded routing: enable and source select (1 = right sample) per output
  typedef struct packed {
    logic leftEn;
    logic leftFromRight;
    logic rightEn;
    logic rightFromRight;
  } route_t;

  function automatic route_t decodeRoute(input logic [3:0] code);
    route_t r;
    r = '0;
    unique case (code)
      4'h0, 4'h6, 4'h9, 4'hF: r = '0;
      4'h5: begin
        r.leftEn  = 1'b1; r.leftFromRight  = 1'b0;
        r.rightEn = 1'b1; r.rightFromRight = 1'b1;
      end
      4'hA: begin
        r.leftEn  = 1'b1; r.leftFromRight  = 1'b1;
        r.rightEn = 1'b1; r.rightFromRight = 1'b0;
      end
      default: begin
        if (code[2] | code[3]) begin
          r.rightEn        = 1'b1;
          r.rightFromRight = code[1] | code[2];
        end else begin
          r.leftEn        = 1'b1;
          r.leftFromRight = code[1] | code[2];
        end
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwm_route_ctrl.sv
module pwm_route_ctrl
  import pwm_route_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] periodNow,
  output logic [SAMPLE_W-1:0] count,
  output pwmStrobes_t         strobes
);

  localparam logic [SAMPLE_W-1:0] ONE = SAMPLE_W'(1);

  logic [SAMPLE_W-1:0] lastCount;
  logic                atWrap;

  assign lastCount = periodNow - ONE;
  assign atWrap    = (count == lastCount);

  always_comb begin
    strobes.running    = (periodNow != '0);
    strobes.loadActive = !strobes.running || atWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else if (strobes.loadActive)
      count <= '0;
    else
      count <= count + ONE;
  end

endmodule

// File: rtl/pwm_route_dp.sv
module pwm_route_dp
  import pwm_route_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MODE_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] periodIn,
  input  logic [MODE_W-1:0]   modeIn,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                sampleStrobe,
  input  pwmStrobes_t         strobes,
  input  logic [SAMPLE_W-1:0] count,
  output logic [SAMPLE_W-1:0] periodNow,
  output logic                pwmLeft,
  output logic                pwmRight
);

  localparam int NUM_CH = 2;  // index 0 = left source, 1 = right source

  logic [SAMPLE_W-1:0] stageSample  [NUM_CH];
  logic [SAMPLE_W-1:0] stageNext    [NUM_CH];
  logic [SAMPLE_W-1:0] activeSample [NUM_CH];
  logic [SAMPLE_W-1:0] inSample     [NUM_CH];
  logic [NUM_CH-1:0]   chHigh;
  logic [MODE_W-1:0]   activeMode;
  route_t              route;

  assign inSample[0] = sampleLeft;
  assign inSample[1] = sampleRight;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] limited;

    assign stageNext[ch] = sampleStrobe ? inSample[ch] : stageSample[ch];
    assign limited       = (activeSample[ch] > periodNow) ? periodNow : activeSample[ch];
    assign chHigh[ch]    = (count < limited);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageSample[ch]  <= '0;
        activeSample[ch] <= '0;
      end else begin
        stageSample[ch] <= stageNext[ch];
        if (strobes.loadActive)
          activeSample[ch] <= stageNext[ch];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodNow  <= '0;
      activeMode <= '0;
    end else if (strobes.loadActive) begin
      periodNow  <= periodIn;
      activeMode <= modeIn;
    end
  end

  assign route = decodeRoute(activeMode);

  always_comb begin
    pwmLeft  = strobes.running && route.leftEn &&
               (route.leftFromRight ? chHigh[1] : chHigh[0]);
    pwmRight = strobes.running && route.rightEn &&
               (route.rightFromRight ? chHigh[1] : chHigh[0]);
  end

endmodule

// File: rtl/pwm_route_mod.sv
module pwm_route_mod
  import pwm_route_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MODE_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] periodIn,
  input  logic [MODE_W-1:0]   modeIn,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                sampleStrobe,
  output logic                pwmLeft,
  output logic                pwmRight
);

  logic [SAMPLE_W-1:0] count;
  logic [SAMPLE_W-1:0] periodNow;
  pwmStrobes_t         strobes;

  pwm_route_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .periodNow (periodNow),
    .count     (count),
    .strobes   (strobes)
  );

  pwm_route_dp #(.SAMPLE_W(SAMPLE_W), .MODE_W(MODE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .periodIn     (periodIn),
    .modeIn       (modeIn),
    .sampleLeft   (sampleLeft),
    .sampleRight  (sampleRight),
    .sampleStrobe (sampleStrobe),
    .strobes      (strobes),
    .count        (count),
    .periodNow    (periodNow),
    .pwmLeft      (pwmLeft),
    .pwmRight     (pwmRight)
  );

endmodule

// File: rtl/pwm_route_chk.sv
module pwm_route_chk #(
  parameter int SAMPLE_W = 12,
  parameter int MODE_W   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [SAMPLE_W-1:0] count,
  input logic [SAMPLE_W-1:0] periodNow,
  input logic [MODE_W-1:0]   modeNow,
  input logic                loadActive,
  input logic                pwmLeft,
  input logic                pwmRight
);

  // R1: outputs low while reset is held
  always @(negedge clk) begin
    if (!rstN)
      p_reset_low_r1: assert (!pwmLeft && !pwmRight)
        else $error("outputs high during reset");
  end

  // R4: muted codes drive nothing
  p_invalid_mute_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 4'h0 || modeNow == 4'h6 || modeNow == 4'h9 || modeNow == 4'hF)
      |-> (!pwmLeft && !pwmRight));

  // R5: single-side codes never drive both outputs
  p_single_side_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow != 4'h5 && modeNow != 4'hA) |-> $onehot0({pwmLeft, pwmRight}));

  // R7: zero period keeps everything quiet
  p_zero_period_r7: assert property (@(posedge clk) disable iff (!rstN)
    (periodNow == '0) |-> (!pwmLeft && !pwmRight && count == '0));

  // R8: a pulse can only begin at the start of a period
  p_rise_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pwmLeft) || $rose(pwmRight)) |-> (count == '0));

  // R9: active settings change only at a load
  p_hold_settings_r9: assert property (@(posedge clk) disable iff (!rstN)
    !loadActive |=> ($stable(modeNow) && $stable(periodNow)));

  // R10: counter stays within the period
  p_count_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (periodNow != '0) |-> (count < periodNow));

endmodule

bind pwm_route_mod pwm_route_chk #(.SAMPLE_W(SAMPLE_W), .MODE_W(MODE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .count      (count),
  .periodNow  (periodNow),
  .modeNow    (u_dp.activeMode),
  .loadActive (strobes.loadActive),
  .pwmLeft    (pwmLeft),
  .pwmRight   (pwmRight)
);

// File: tb/pwm_route_mod_tb.sv
module pwm_route_mod_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] periodIn = '0;
  logic [3:0]  modeIn = '0;
  logic [11:0] sampleLeft = '0;
  logic [11:0] sampleRight = '0;
  logic        sampleStrobe = 1'b0;
  logic        pwmLeft, pwmRight;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_route_mod u_dut (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .modeIn(modeIn),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .sampleStrobe(sampleStrobe), .pwmLeft(pwmLeft), .pwmRight(pwmRight)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Return to the stopped state, then load a fresh setting; count is 0 after return
  task automatic loadSetting(input int p, input logic [3:0] m, input int sl, input int sr);
    @(negedge clk);
    periodIn = '0;
    repeat (16) @(negedge clk);
    periodIn = 12'(p);
    modeIn = m;
    sampleLeft = 12'(sl);
    sampleRight = 12'(sr);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
  endtask

  // Observe one period; count cycles that break the expected high-then-low shape
  task automatic watchPeriod(input int p, input int expL, input int expR,
                             input string req);
    int badL = 0, badR = 0, hiL = 0, hiR = 0;
    for (int i = 0; i < p; i++) begin
      if (pwmLeft !== (i < expL)) badL++;
      if (pwmRight !== (i < expR)) badR++;
      if (pwmLeft) hiL++;
      if (pwmRight) hiR++;
      @(negedge clk);
    end
    check(badL == 0, {req, " left"}, hiL, expL);
    check(badR == 0, {req, " right"}, hiR, expR);
  endtask

  task automatic testReset();
    int bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (pwmLeft || pwmRight) bad++;
    end
    rstN = 1'b1;
    @(negedge clk);
    if (pwmLeft || pwmRight) bad++;
    check(bad == 0, "R1 reset low", bad, 0);
  endtask

  task automatic testNormal();
    loadSetting(10, 4'h5, 3, 7);
    watchPeriod(10, 3, 7, "R2 normal first");
    watchPeriod(10, 3, 7, "R10 normal repeat");
    loadSetting(8, 4'h5, 0, 5);
    watchPeriod(8, 0, 5, "R8 zero sample");
  endtask

  task automatic testSwap();
    loadSetting(9, 4'hA, 2, 6);
    watchPeriod(9, 6, 2, "R3 swap");
  endtask

  task automatic testMuted();
    logic [3:0] codes [4] = '{4'h0, 4'h6, 4'h9, 4'hF};
    foreach (codes[k]) begin
      loadSetting(8, codes[k], 5, 6);
      watchPeriod(8, 0, 0, "R4 muted");
    end
  endtask

  // Expected per R5: code -> (source right?, destination right?)
  task automatic testMono();
    logic [3:0] codes [6] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'hC, 4'hE};
    bit srcR [6] = '{0, 1, 1, 0, 1, 1};
    bit dstR [6] = '{0, 0, 1, 1, 1, 1};
    foreach (codes[k]) begin
      int v = srcR[k] ? 6 : 3;
      loadSetting(10, codes[k], 3, 6);
      watchPeriod(10, dstR[k] ? 0 : v, dstR[k] ? v : 0, "R5 mono");
    end
  endtask

  task automatic testClamp();
    loadSetting(6, 4'h5, 4095, 6);
    watchPeriod(6, 6, 6, "R6 clamp large");
    loadSetting(6, 4'h5, 7, 5);
    watchPeriod(6, 6, 5, "R6 clamp by one");
  endtask

  task automatic testZeroPeriod();
    int bad = 0;
    loadSetting(0, 4'h5, 100, 200);
    for (int i = 0; i < 20; i++) begin
      if (pwmLeft || pwmRight) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R7 zero period", bad, 0);
  endtask

  // Mid-period strobe and code change appear only in the next period
  task automatic testMidLatch();
    int badL = 0, badR = 0;
    loadSetting(10, 4'h5, 7, 2);
    for (int i = 0; i < 10; i++) begin
      if (pwmLeft !== (i < 7)) badL++;
      if (pwmRight !== (i < 2)) badR++;
      if (i == 3) begin
        sampleLeft = 12'd2;
        sampleRight = 12'd9;
        modeIn = 4'hA;
        sampleStrobe = 1'b1;
        @(negedge clk);
        sampleStrobe = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check(badL == 0, "R9 hold left", badL, 0);
    check(badR == 0, "R9 hold right", badR, 0);
    watchPeriod(10, 9, 2, "R9 next period");
  endtask

  // Strobe landing exactly on the wrap cycle loads its own value
  task automatic testStrobeAtWrap();
    loadSetting(6, 4'h5, 1, 1);
    repeat (5) @(negedge clk);
    sampleLeft = 12'd4;
    sampleRight = 12'd3;
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    watchPeriod(6, 4, 3, "R9 strobe at wrap");
  endtask

  initial begin
    testReset();
    testNormal();
    testSwap();
    testMuted();
    testMono();
    testClamp();
    testZeroPeriod();
    testMidLatch();
    testStrobeAtWrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule